// File: doc/BRIEF.md
# System Clock Mode Register

This block holds a single byte-wide control register on a simple memory-mapped bus. The register chooses where the internal system clock comes from and how much it is slowed down. There are three possible sources: an on-chip oscillator, an external main oscillator and a low-speed sub oscillator. From the stored value the block drives the enables of the two external oscillators, a stack page bit and the processor mode field. It also drives a clock-enable pulse at the chosen system rate.

Every oscillator is modelled as a one-cycle tick input in a single base clock domain. The output `sys_ce` is a one-cycle pulse that fires once for every N ticks of the chosen source. N is 8 for the on-chip oscillator, 2 or 8 for the main oscillator, and 1 for the sub oscillator. When the effective source, ratio or source availability changes, the divider starts again from zero. This means the first pulse after a switch always comes after a full period. After reset the block runs from the on-chip oscillator and both external oscillators are off.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the register reads 0x68 at address 0x3B. `main_osc_en`, `sub_osc_en`, `stack_page` and `proc_mode` are all 0.
- R2: A write with `bus_addr` = 0x3B stores the full byte on the next clock edge, and a read at 0x3B returns it. A read at any other address returns 0x00. A write to any other address changes neither the register nor any output.
- R3: `main_osc_en` is the inverse of bit 5 (1 = main oscillator stopped). `sub_osc_en` equals bit 4 (1 = sub oscillator running).
- R4: `stack_page` equals bit 2. `proc_mode` follows bits 1:0 when they are 00 (single-chip). Any other code is stored and reads back unchanged, but `proc_mode` is forced to 00.
- R5: With bit 7 = 0 and bit 3 = 1, the on-chip oscillator is used. `sys_ce` pulses once per 8 on-chip ticks, whatever the value of bit 6.
- R6: With bit 7 = 0 and bit 3 = 0, the main oscillator is used. `sys_ce` pulses once per 2 main ticks when bit 6 = 0, and once per 8 when bit 6 = 1.
- R7: With bit 7 = 1, the sub oscillator is used and `sys_ce` pulses on every sub tick. Bits 3 and 6 have no effect.
- R8: If the selected source is stopped, `sys_ce` stays low. This is the main oscillator with bit 5 = 1, or the sub oscillator with bit 4 = 0. The register value is still stored.
- R9: Ticks from the sources that are not selected never cause a `sys_ce` pulse.
- R10: After a change of effective source, ratio or availability, the divider restarts. The first `sys_ce` comes on exactly the N-th tick of the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Bus byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| osc_int_tick | input | 1 | On-chip oscillator tick |
| osc_main_tick | input | 1 | Main oscillator tick |
| osc_sub_tick | input | 1 | Sub oscillator tick |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| stack_page | output | 1 | Stack page select |
| proc_mode | output | 2 | Processor mode (always legal) |
| sys_ce | output | 1 | System clock-enable pulse |

## Verification
A table of register values is walked while all three ticks run every cycle. For each value, the number of `sys_ce` pulses over 16 ticks is counted, which gives 16, 8, 2 or 0 pulses. These counts separate sub, main-divided-by-2 and divided-by-8 operation from a stopped source. Pairs of table values differ only in bit 6 or only in bit 3. With these pairs the bench checks that the ratio bit matters for the main oscillator and is ignored for the on-chip oscillator and for low-speed mode. Directed runs feed only the unselected ticks, write to a foreign address, and switch source halfway through a count. This shows that the first pulse after a switch is not shortened.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam logic [7:0] CMR_ADDR  = 8'h3B;
  localparam logic [7:0] CMR_RESET = 8'h68;
  localparam int         RATIO_W   = 4;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_SUB  = 2'd2
  } src_e;

  typedef struct packed {
    src_e               src;
    logic [RATIO_W-1:0] ratio;
    logic               avail;
  } clkcfg_t;

  // Effective clock configuration for a register value.
  function automatic clkcfg_t decode_cfg(input logic [7:0] r);
    clkcfg_t c;
    if (r[7]) begin
      c.src   = SRC_SUB;
      c.ratio = 4'd1;
      c.avail = r[4];
    end else if (r[3]) begin
      c.src   = SRC_INT;
      c.ratio = 4'd8;
      c.avail = 1'b1;
    end else begin
      c.src   = SRC_MAIN;
      c.ratio = r[6] ? 4'd8 : 4'd2;
      c.avail = ~r[5];
    end
    return c;
  endfunction

  // Processor mode output: reserved codes collapse to single-chip.
  function automatic logic [1:0] legal_mode(input logic [1:0] m);
    return (m == 2'b00) ? 2'b00 : 2'b00;
  endfunction

endpackage

// File: rtl/clkmode_regfile.sv
module clkmode_regfile #(
  parameter int              ADDR_W    = 8,
  parameter logic [7:0]      RESET_VAL = clkmode_pkg::CMR_RESET,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(clkmode_pkg::CMR_ADDR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        cmr_q,
  output logic              main_osc_en,
  output logic              sub_osc_en,
  output logic              stack_page,
  output logic [1:0]        proc_mode
);
  import clkmode_pkg::*;

  logic hit;
  logic wr_hit;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_we && hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      cmr_q <= RESET_VAL;
    else if (wr_hit) cmr_q <= bus_wdata;
  end

  assign bus_rdata   = hit ? cmr_q : 8'h00;
  assign main_osc_en = ~cmr_q[5];
  assign sub_osc_en  = cmr_q[4];
  assign stack_page  = cmr_q[2];
  assign proc_mode   = legal_mode(cmr_q[1:0]);

  p_write_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (main_osc_en == !$past(bus_wdata[5])) && (sub_osc_en == $past(bus_wdata[4])));

  p_foreign_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> $stable(cmr_q));

  p_page_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> stack_page == $past(bus_wdata[2]));

  p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    proc_mode == 2'b00);

endmodule

// File: rtl/clkmode_srcsel.sv
module clkmode_srcsel (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            cmr_q,
  input  logic                  osc_int_tick,
  input  logic                  osc_main_tick,
  input  logic                  osc_sub_tick,
  output clkmode_pkg::clkcfg_t  cfg,
  output logic                  sel_tick
);
  import clkmode_pkg::*;

  logic raw_tick;

  assign cfg = decode_cfg(cmr_q);

  always_comb begin
    unique case (cfg.src)
      SRC_INT:  raw_tick = osc_int_tick;
      SRC_MAIN: raw_tick = osc_main_tick;
      SRC_SUB:  raw_tick = osc_sub_tick;
      default:  raw_tick = 1'b0;
    endcase
  end

  assign sel_tick = raw_tick && cfg.avail;

  p_sub_overrides_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmr_q[7] |-> (sel_tick == (osc_sub_tick && cmr_q[4])));

  p_int_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmr_q[7] && cmr_q[3]) |-> cfg.ratio == 4'd8);

endmodule

// File: rtl/clkmode_divider.sv
module clkmode_divider #(
  parameter int MAX_DIV = 8,
  localparam int CW     = $clog2(MAX_DIV)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  clkmode_pkg::clkcfg_t cfg,
  input  logic                 sel_tick,
  output logic                 restart,
  output logic                 sys_ce
);
  import clkmode_pkg::*;

  clkcfg_t       cfg_q;
  logic [CW-1:0] cnt;
  logic          last;

  assign restart = (cfg != cfg_q);
  assign last    = ({{(RATIO_W-CW){1'b0}}, cnt} == (cfg.ratio - 4'd1));
  assign sys_ce  = sel_tick && !restart && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= decode_cfg(CMR_RESET);
      cnt   <= '0;
    end else begin
      cfg_q <= cfg;
      if (restart)       cnt <= '0;
      else if (sel_tick) cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);

  p_ce_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce |-> sel_tick);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> ({{(RATIO_W-CW){1'b0}}, cnt} < cfg.ratio));

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
  parameter int         ADDR_W  = 8,
  parameter int         MAX_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              osc_int_tick,
  input  logic              osc_main_tick,
  input  logic              osc_sub_tick,
  output logic              main_osc_en,
  output logic              sub_osc_en,
  output logic              stack_page,
  output logic [1:0]        proc_mode,
  output logic              sys_ce
);
  import clkmode_pkg::*;

  logic [7:0] cmr_q;
  clkcfg_t    cfg;
  logic       sel_tick;
  logic       restart;

  clkmode_regfile #(.ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmr_q(cmr_q),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
    .stack_page(stack_page), .proc_mode(proc_mode)
  );

  clkmode_srcsel u_sel (
    .clk(clk), .rst_n(rst_n), .cmr_q(cmr_q),
    .osc_int_tick(osc_int_tick), .osc_main_tick(osc_main_tick),
    .osc_sub_tick(osc_sub_tick), .cfg(cfg), .sel_tick(sel_tick)
  );

  clkmode_divider #(.MAX_DIV(MAX_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .sel_tick(sel_tick),
    .restart(restart), .sys_ce(sys_ce)
  );

  p_stopped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.avail |-> !sys_ce);

  p_ce_oscen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ce && cfg.src == SRC_MAIN) |-> main_osc_en);

endmodule

// File: tb/clkmode_ctrl_tb.sv
`timescale 1ns/1ps
module clkmode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       t_int = 1'b0, t_main = 1'b0, t_sub = 1'b0;
  logic       main_osc_en, sub_osc_en, stack_page, sys_ce;
  logic [1:0] proc_mode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  clkmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_int_tick(t_int), .osc_main_tick(t_main), .osc_sub_tick(t_sub),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
    .stack_page(stack_page), .proc_mode(proc_mode), .sys_ce(sys_ce)
  );

  // {wdata, pulses per 16 ticks, main_en, sub_en}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {8'h68, 8'd2,  1'b0, 1'b0},  // R5 on-chip /8
    {8'h28, 8'd2,  1'b0, 1'b0},  // R5 on-chip, b6 ignored
    {8'h00, 8'd8,  1'b1, 1'b0},  // R6 main /2
    {8'h40, 8'd2,  1'b1, 1'b0},  // R6 main /8
    {8'h20, 8'd0,  1'b0, 1'b0},  // R8 main stopped
    {8'h90, 8'd16, 1'b1, 1'b1},  // R7 sub
    {8'h80, 8'd0,  1'b1, 1'b0},  // R8 sub stopped
    {8'hD8, 8'd16, 1'b1, 1'b1},  // R7 sub, b3/b6 ignored
    {8'h03, 8'd8,  1'b1, 1'b0},  // R4 reserved mode
    {8'h04, 8'd8,  1'b1, 1'b0}   // R4 stack page 1
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h3B;
    repeat (2) @(negedge clk);
  endtask

  // drive n cycles with the chosen ticks; return pulses seen
  task automatic run(input int n, input bit ti, input bit tm, input bit ts, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t_int = ti; t_main = tm; t_sub = ts;
      #1;
      if (sys_ce) pulses++;
    end
    @(negedge clk);
    t_int = 1'b0; t_main = 1'b0; t_sub = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 8'h3B;
    #1;
    chk("R1 reset value", bus_rdata, 8'h68);
    chk("R1 main_osc_en", main_osc_en, 0);
    chk("R1 sub_osc_en", sub_osc_en, 0);
    chk("R1 stack_page", stack_page, 0);
    chk("R1 proc_mode", proc_mode, 0);

    for (int v = 0; v < NV; v++) begin
      wr(8'h3B, VEC[v][17:10]);
      #1;
      chk("R2 readback", bus_rdata, VEC[v][17:10]);
      chk("R3 main_osc_en", main_osc_en, VEC[v][1]);
      chk("R3 sub_osc_en", sub_osc_en, VEC[v][0]);
      chk("R4 stack_page", stack_page, VEC[v][12]);
      chk("R4 proc_mode", proc_mode, 0);
      run(16, 1'b1, 1'b1, 1'b1, p);
      chk("R5/R6/R7/R8 pulse count", p, VEC[v][9:2]);
    end

    // R2: foreign address read and write
    wr(8'h3B, 8'h00);
    bus_addr = 8'h3A; #1;
    chk("R2 foreign read", bus_rdata, 0);
    wr(8'h3C, 8'hB0);
    #1;
    chk("R2 foreign write ignored", bus_rdata, 8'h00);
    chk("R2 foreign write osc", main_osc_en, 1);
    run(16, 1'b0, 1'b1, 1'b0, p);
    chk("R2 foreign write rate", p, 8);

    // R9: only unselected ticks
    run(16, 1'b1, 1'b0, 1'b1, p);
    chk("R9 main selected, others ticking", p, 0);
    wr(8'h3B, 8'h90);
    run(16, 1'b1, 1'b1, 1'b0, p);
    chk("R9 sub selected, others ticking", p, 0);

    // R10: switch mid-count, first pulse needs full 8 ticks
    wr(8'h3B, 8'h68);
    run(3, 1'b1, 1'b0, 1'b0, p);
    wr(8'h3B, 8'h40);
    run(7, 1'b0, 1'b1, 1'b0, p);
    chk("R10 no early pulse", p, 0);
    run(1, 1'b0, 1'b1, 1'b0, p);
    chk("R10 pulse on 8th tick", p, 1);

    // R8: enabling a stopped source resumes pulses
    wr(8'h3B, 8'h20);
    run(8, 1'b0, 1'b1, 1'b0, p);
    chk("R8 stopped main", p, 0);
    wr(8'h3B, 8'h00);
    run(2, 1'b0, 1'b1, 1'b0, p);
    chk("R8 main resumed", p, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule